// File: doc/BRIEF.md
# Edge-Signalled Link with Level Refresh and Loss-of-Link Watchdog

This block carries a group of slow or static logic levels across a channel that only passes discrete packets. The transmitter turns every input transition into an edge packet right away. When the inputs stay quiet for a set number of clock cycles, it sends a refresh packet instead. A refresh packet holds a snapshot of all input levels, all taken in the same cycle. The receiver keeps one set/clear latch per channel. Edge packets update the latch bits they name, and refresh packets overwrite every latch bit, which repairs any level that has drifted.

A receive watchdog counts cycles since the last packet that passed the parity check. When that count reaches its limit, the outputs are released to high impedance, shown at the ports as a single output-enable going low. Only a valid refresh packet can turn the outputs on again, because only a refresh restores every level at once. The transmit and receive halves are both exposed, so they can be joined directly or through any packet transport.

A packet is `2*NCH+2` bits wide:
- bit `2*NCH+1` is the kind: 0 for an edge packet, 1 for a refresh packet.
- bits `2*NCH:NCH+1` are the change mask. It is zero in a refresh packet.
- bits `NCH:1` are the levels.
- bit 0 makes the XOR of the whole packet equal to zero (even parity).

Top module: `edge_refresh_link`

## Requirements
- R1: When any input differs from its value in the previous cycle, the transmitter sends an edge packet in the next cycle. The packet has kind 0 in bit `2*NCH+1`, the set of changed inputs as the mask in bits `2*NCH:NCH+1`, the current input levels in bits `NCH:1`, and even parity over the whole packet.
- R2: After `REFRESH_CYC` consecutive cycles with no input transition, the transmitter sends a refresh packet. The packet has kind 1, a zero mask, the levels of all inputs sampled in one cycle, and even parity.
- R3: A good edge packet changes only the latch bits whose mask bit is 1, setting each to its level bit, one cycle after the packet arrives.
- R4: A good refresh packet loads every latch bit from its level field one cycle after it arrives, correcting any output that disagreed.
- R5: When `WDOG_CYC` cycles pass after the last good packet with no further good packet, `rx_oe` goes low.
- R6: While `rx_oe` is low, good edge packets do not raise it. The first good refresh packet raises `rx_oe` one cycle after it arrives, with the refreshed levels on `rx_dout`.
- R7: A packet whose bits XOR to 1 is discarded. It changes no latch bit, does not raise `rx_oe`, and does not restart the watchdog.
- R8: After reset, `tx_pkt_vld` is 0, `rx_dout` is all zeros and `rx_oe` is 0.
- R9: Several inputs that change in the same cycle travel in a single edge packet, with all of their mask bits set.
- R10: An edge packet restarts the refresh interval, so the next refresh follows `REFRESH_CYC` cycles after the last edge packet if the inputs stay quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_din | input | NCH | Levels to be carried across |
| tx_pkt_vld | output | 1 | Transmit packet valid, one cycle per packet |
| tx_pkt | output | 2*NCH+2 | Transmit packet |
| rx_pkt_vld | input | 1 | Receive packet valid |
| rx_pkt | input | 2*NCH+2 | Receive packet |
| rx_dout | output | NCH | Latched levels |
| rx_oe | output | 1 | Output enable; 0 means outputs are high impedance |

## Verification
Each result has a fixed latency:
- A transmit packet is due one cycle after the input change that causes it.
- A latch or enable change is due one cycle after the packet arrives, which is two cycles from an input change when transmit is looped back to receive.
- A refresh is due exactly `REFRESH_CYC` cycles after the last edge packet.
- The enable drop is due exactly `WDOG_CYC` cycles after the last good packet.

The bench drives inputs on the falling edge and counts rising edges up to the cycle where each result is due. It samples on the following falling edge. For the refresh and watchdog windows it checks both the last cycle before the event and the cycle of the event.

// File: rtl/erl_pkg.sv
package erl_pkg;

    typedef enum logic {
        PK_EDGE    = 1'b0,
        PK_REFRESH = 1'b1
    } pkt_kind_e;

    // Even-parity test over a zero-extended packet: 1 when the XOR of all bits is 0.
    function automatic logic par_even(input logic [63:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/erl_tx.sv
module erl_tx
    import erl_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int REFRESH_CYC = 150,
    parameter int PW          = 2 * NCH + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    output logic           pkt_vld,
    output logic [PW-1:0]  pkt
);

    localparam int CW = $clog2(REFRESH_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(REFRESH_CYC - 1);

    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [CW-1:0]  cnt;
        logic           vld;
        logic [PW-1:0]  pkt;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [NCH-1:0] chg;

    function automatic logic [PW-1:0] build(input pkt_kind_e k,
                                            input logic [NCH-1:0] m,
                                            input logic [NCH-1:0] l);
        logic [PW-2:0] body;
        body = {k, m, l};
        return {body, ^body};
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        st_d.vld  = 1'b0;
        chg       = din ^ st_q.prev;
        if (chg != '0) begin
            st_d.vld = 1'b1;
            st_d.pkt = build(PK_EDGE, chg, din);
            st_d.cnt = '0;
        end else if (st_q.cnt == LIM) begin
            st_d.vld = 1'b1;
            st_d.pkt = build(PK_REFRESH, '0, din);
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_vld = st_q.vld;
    assign pkt     = st_q.pkt;

    AST_TX_EDGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (din != $past(din)) |=> pkt_vld && !pkt[PW-1] && (pkt[NCH:1] == $past(din))); // R1

    AST_TX_REFRESH_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld && pkt[PW-1] |-> (pkt[NCH:1] == $past(din)) && (pkt[2*NCH:NCH+1] == '0)); // R2

endmodule

// File: rtl/erl_rx_wdog.sv
module erl_rx_wdog #(
    parameter int WDOG_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good,
    output logic expire
);

    localparam int CW = $clog2(WDOG_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(WDOG_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (good) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LIM) begin
            expire = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM); // R5

    AST_WD_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> !expire); // R5

endmodule

// File: rtl/erl_rx_latch.sv
module erl_rx_latch
    import erl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int PW  = 2 * NCH + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pkt_vld,
    input  logic [PW-1:0]  pkt,
    input  logic           expire,
    output logic           good,
    output logic [NCH-1:0] dout,
    output logic           oe
);

    typedef struct packed {
        logic [NCH-1:0] lat;
        logic           oe;
    } rx_state_t;

    rx_state_t st_d, st_q;
    pkt_kind_e      kind;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] lvl;

    assign kind = pkt_kind_e'(pkt[PW-1]);
    assign mask = pkt[2*NCH:NCH+1];
    assign lvl  = pkt[NCH:1];
    assign good = pkt_vld && par_even(64'(pkt));

    always_comb begin
        st_d = st_q;
        if (good && kind == PK_REFRESH) begin
            st_d.lat = lvl;
            st_d.oe  = 1'b1;
        end else if (good) begin
            st_d.lat = (st_q.lat & ~mask) | (lvl & mask);
        end else if (expire) begin
            st_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lat;
    assign oe   = st_q.oe;

    AST_RX_EDGE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        good && !pkt[PW-1] |=> ((dout & ~$past(mask)) == ($past(dout) & ~$past(mask)))
                              && ((dout & $past(mask)) == ($past(lvl) & $past(mask)))); // R3

    AST_RX_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        good && pkt[PW-1] |=> (dout == $past(lvl)) && oe); // R4

    AST_RX_TIMEOUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !oe); // R5

    AST_RX_OE_ONLY_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(good && pkt[PW-1])); // R6

    AST_RX_BAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld && (^pkt) |=> $stable(dout)); // R7

endmodule

// File: rtl/edge_refresh_link.sv
module edge_refresh_link #(
    parameter int NCH         = 4,
    parameter int REFRESH_CYC = 150,
    parameter int WDOG_CYC    = 625
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     tx_din,
    output logic               tx_pkt_vld,
    output logic [2*NCH+1:0]   tx_pkt,
    input  logic               rx_pkt_vld,
    input  logic [2*NCH+1:0]   rx_pkt,
    output logic [NCH-1:0]     rx_dout,
    output logic               rx_oe
);

    localparam int PW = 2 * NCH + 2;

    logic good;
    logic expire;

    erl_tx #(.NCH(NCH), .REFRESH_CYC(REFRESH_CYC), .PW(PW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (tx_din),
        .pkt_vld (tx_pkt_vld),
        .pkt     (tx_pkt)
    );

    erl_rx_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .good   (good),
        .expire (expire)
    );

    erl_rx_latch #(.NCH(NCH), .PW(PW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt_vld (rx_pkt_vld),
        .pkt     (rx_pkt),
        .expire  (expire),
        .good    (good),
        .dout    (rx_dout),
        .oe      (rx_oe)
    );

    AST_TOP_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rx_oe); // R8

endmodule

// File: tb/edge_refresh_link_bench.sv
module edge_refresh_link_bench;

    localparam int NCH = 4;
    localparam int RC  = 12;
    localparam int WC  = 30;
    localparam int PW  = 2 * NCH + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] din = '0;
    logic tx_vld;
    logic [PW-1:0] tx_pkt;
    logic inj_en = 1'b0;
    logic inj_vld = 1'b0;
    logic [PW-1:0] inj_pkt = '0;
    logic rx_vld;
    logic [PW-1:0] rx_pkt;
    logic [NCH-1:0] dout;
    logic oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign rx_vld = inj_en ? inj_vld : tx_vld;
    assign rx_pkt = inj_en ? inj_pkt : tx_pkt;

    edge_refresh_link #(.NCH(NCH), .REFRESH_CYC(RC), .WDOG_CYC(WC)) u_edge_refresh_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_din     (din),
        .tx_pkt_vld (tx_vld),
        .tx_pkt     (tx_pkt),
        .rx_pkt_vld (rx_vld),
        .rx_pkt     (rx_pkt),
        .rx_dout    (dout),
        .rx_oe      (oe)
    );

    // {din, expected mask}
    localparam logic [7:0] VEC [8] = '{
        8'b0001_0001, 8'b0011_0010, 8'b1100_1111, 8'b1101_0001,
        8'b0101_1000, 8'b1010_1111, 8'b0000_1010, 8'b1111_1111
    };

    function automatic logic [PW-1:0] mk(input logic k, input logic [NCH-1:0] m,
                                         input logic [NCH-1:0] l, input logic corrupt);
        logic [PW-2:0] b;
        b = {k, m, l};
        return {b, (^b) ^ corrupt};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic inject(input logic [PW-1:0] p);
        inj_pkt = p;
        inj_vld = 1'b1;
        cyc(1);
        inj_vld = 1'b0;
    endtask

    initial begin
        int quiet_bad;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 tx idle", tx_vld, 0);
        chk("R8 dout zero", dout, 0);
        chk("R8 oe low", oe, 0);

        cyc(11);
        chk("R2 no refresh early", tx_vld, 0);
        cyc(1);
        chk("R2 refresh pkt", {tx_vld, tx_pkt}, {1'b1, mk(1'b1, 4'b0, 4'b0, 1'b0)});
        cyc(1);
        chk("R6 oe after first refresh", oe, 1);

        for (int i = 0; i < 8; i++) begin
            din = VEC[i][7:4];
            cyc(1);
            chk("R1 R9 edge pkt", {tx_vld, tx_pkt}, {1'b1, mk(1'b0, VEC[i][3:0], VEC[i][7:4], 1'b0)});
            cyc(1);
            chk("R3 latch follows", {oe, dout}, {1'b1, VEC[i][7:4]});
        end

        // R10: edge restarts the refresh interval
        din = 4'b1110;
        cyc(1);
        chk("R10 edge pkt", {tx_vld, tx_pkt}, {1'b1, mk(1'b0, 4'b0001, 4'b1110, 1'b0)});
        quiet_bad = 0;
        for (int i = 0; i < RC - 1; i++) begin
            cyc(1);
            if (tx_vld) quiet_bad++;
        end
        chk("R10 quiet window", quiet_bad, 0);
        cyc(1);
        chk("R10 R2 refresh", {tx_vld, tx_pkt}, {1'b1, mk(1'b1, 4'b0, 4'b1110, 1'b0)});

        inj_en = 1'b1;
        inject(mk(1'b0, 4'b0010, 4'b0000, 1'b0));
        chk("R3 mask only", {oe, dout}, {1'b1, 4'b1100});
        inject(mk(1'b1, 4'b0000, 4'b1110, 1'b0));
        chk("R4 refresh corrects", dout, 4'b1110);
        inject(mk(1'b0, 4'b1111, 4'b0000, 1'b1));
        chk("R7 bad edge ignored", dout, 4'b1110);

        // R5 with R7: bad packets do not restart the watchdog
        inject(mk(1'b1, 4'b0000, 4'b1110, 1'b0));
        inj_pkt = mk(1'b1, 4'b0000, 4'b0001, 1'b1);
        inj_vld = 1'b1;
        cyc(WC - 1);
        chk("R5 oe before limit", oe, 1);
        chk("R7 bad refresh ignored", dout, 4'b1110);
        inj_vld = 1'b0;
        cyc(1);
        chk("R5 R7 oe drops at limit", oe, 0);

        inject(mk(1'b0, 4'b1111, 4'b0101, 1'b0));
        chk("R6 edge keeps hiz", oe, 0);
        inject(mk(1'b1, 4'b0000, 4'b0011, 1'b1));
        chk("R7 bad refresh no enable", oe, 0);
        inject(mk(1'b1, 4'b0000, 4'b0011, 1'b0));
        chk("R6 refresh enables", {oe, dout}, {1'b1, 4'b0011});

        inj_en = 1'b0;
        cyc(RC + 2);
        chk("R4 link refresh restores", {oe, dout}, {1'b1, 4'b1110});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule